// File: doc/BRIEF.md
# Banked Interrupt Vector Controller

The controller gathers a wide set of edge-type interrupt sources into sticky pending bits and presents them to software as banked 32-bit words behind a small register port. A source sets its pending bit on a low-to-high transition. The bit stays set until software acknowledges it by writing a one to that bit position. Writing zero to a bit leaves it as it was.

A separate bank of enable words decides which pending vectors reach the single parent interrupt output. Masking a vector hides it from the parent line but does not stop it from being captured. Software can therefore poll a masked vector or unmask it later and still see an edge that came earlier.

The register port is a single-cycle request interface. A write takes effect at the clock edge that accepts it. Read data is registered and appears in the cycle after the request. Vector `v` lives in word `v/32` at bit `v%32`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every pending and enable bit is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A 0-to-1 transition of `src_i[v]` sets pending bit `v%32` of the pending word at byte offset `4*(v/32)` (offsets 0x00, 0x04, 0x08, 0x0C) at the clock edge that samples the new level.
- R3: Capture is edge-only. A source held high does not set its bit again after an acknowledge; a new rise is needed.
- R4: A write to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: The enable words sit at byte offsets 0x20, 0x24, 0x28 and 0x2C, one per group of 32 vectors. A write replaces the whole word, and a read returns the value last written.
- R6: `irq_o` is 1 exactly when some vector is both pending and enabled. It follows the stored state in the cycle after that state changes.
- R7: If a rising edge and a write-one-to-clear hit the same bit in the same cycle, the bit stays pending.
- R8: Offsets 0x10–0x1C and 0x30–0x3C, and any address whose two low bits are not 00, are unmapped. Reads there return 0, and writes there change no pending or enable bit.
- R9: A masked vector (enable 0) is still captured into its pending bit and can be read back.
- R10: A read request loads `rdata_o` at the next clock edge. `rdata_o` holds its value on cycles with no read request, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Interrupt source levels; a rise marks an event |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Parent interrupt, high while any enabled vector is pending |

## Verification
The assertions assume that sources and bus signals are synchronous to `clk_i` and change only between clock edges. They also assume that a request lasts exactly one cycle, with `we_i`, `addr_i` and `wdata_i` valid while `req_i` is high.

The bench meets these assumptions by driving every input on the falling clock edge and dropping `req_i` after each access. It also raises a source only after that source has been low for at least one sampled cycle, so that every intended edge is seen. The one deliberate collision is the same-cycle rise and acknowledge, which is built on one falling edge so that both land on the same rising edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqv_edge.sv
module irqv_edge #(
  parameter int N = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;

  // a bit can never report a rise two cycles running
  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqv_decode.sv
module irqv_decode
  import irqv_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int N_WORDS  = 4,
  parameter int PEND_OFF = 'h00,
  parameter int EN_OFF   = 'h20
) (
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output reg_sel_e                    sel_o,
  output logic [$clog2(N_WORDS)-1:0]  idx_o,
  output logic [N_WORDS-1:0]          pend_we_o,
  output logic [N_WORDS-1:0]          en_we_o
);
  localparam int IDX_W    = $clog2(N_WORDS);
  localparam int BANK_LSB = IDX_W + 2;
  localparam int BANK_W   = ADDR_W - BANK_LSB;
  localparam logic [BANK_W-1:0] PEND_BANK = BANK_W'(PEND_OFF >> BANK_LSB);
  localparam logic [BANK_W-1:0] EN_BANK   = BANK_W'(EN_OFF >> BANK_LSB);

  logic aligned;
  logic [BANK_W-1:0] bank;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign bank    = addr_i[ADDR_W-1:BANK_LSB];
  assign idx_o   = addr_i[BANK_LSB-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (aligned && bank == PEND_BANK) sel_o = SEL_PEND;
    else if (aligned && bank == EN_BANK) sel_o = SEL_EN;
  end

  always_comb begin
    pend_we_o = '0;
    en_we_o   = '0;
    if (req_i && we_i) begin
      if (sel_o == SEL_PEND) pend_we_o[idx_o] = 1'b1;
      if (sel_o == SEL_EN)   en_we_o[idx_o]   = 1'b1;
    end
  end
endmodule

// File: rtl/irqv_word.sv
module irqv_word #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o
);
  logic [W-1:0] pend_q, en_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  // new edge wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr & ~rise_i) != '0) |=> ((pend_q & $past(clr & ~rise_i)) == '0));
  p_enable_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_q == $past(wdata_i)));
  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_i & clr) != '0) |=> ((pend_q & $past(rise_i & clr)) == $past(rise_i & clr)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int N_VEC    = 128,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int PEND_OFF = 'h00,
  parameter int EN_OFF   = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_VEC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int N_WORDS = N_VEC / WORD_W;
  localparam int IDX_W   = $clog2(N_WORDS);

  logic [N_VEC-1:0]   rise;
  reg_sel_e           sel;
  logic [IDX_W-1:0]   idx;
  logic [N_WORDS-1:0] pend_we, en_we, hit;
  logic [WORD_W-1:0]  pend_w [N_WORDS];
  logic [WORD_W-1:0]  en_w   [N_WORDS];
  logic [WORD_W-1:0]  rd_val, rdata_q;

  irqv_edge #(.N(N_VEC)) u_edge (
    .clk_i, .rst_ni, .src_i, .rise_o(rise)
  );

  irqv_decode #(
    .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .PEND_OFF(PEND_OFF), .EN_OFF(EN_OFF)
  ) u_dec (
    .req_i, .we_i, .addr_i, .sel_o(sel), .idx_o(idx),
    .pend_we_o(pend_we), .en_we_o(en_we)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    irqv_word #(.W(WORD_W)) u_word (
      .clk_i, .rst_ni,
      .rise_i  (rise[k*WORD_W +: WORD_W]),
      .clr_we_i(pend_we[k]),
      .en_we_i (en_we[k]),
      .wdata_i,
      .pend_o  (pend_w[k]),
      .en_o    (en_w[k])
    );
    assign hit[k] = |(pend_w[k] & en_w[k]);
  end

  assign irq_o = |hit;

  always_comb begin
    unique case (sel)
      SEL_PEND: rd_val = pend_w[idx];
      SEL_EN:   rd_val = en_w[idx];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  logic any_en;
  always_comb begin
    any_en = 1'b0;
    for (int k = 0; k < N_WORDS; k++) any_en = any_en | (|en_w[k]);
  end

  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en |-> !irq_o);
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel == SEL_NONE) |=> (rdata_o == '0));
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0]  rd;

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // entry: [70] write, [69:64] addr, [63:32] wdata, [31:0] expected read
  localparam logic [70:0] TBL [14] = '{
    {1'b1, 6'h20, 32'hA5A5_A5A5, 32'h0},
    {1'b0, 6'h20, 32'h0,         32'hA5A5_A5A5},
    {1'b1, 6'h24, 32'h0000_FFFF, 32'h0},
    {1'b0, 6'h24, 32'h0,         32'h0000_FFFF},
    {1'b1, 6'h2C, 32'h8000_0001, 32'h0},
    {1'b0, 6'h2C, 32'h0,         32'h8000_0001},
    {1'b0, 6'h28, 32'h0,         32'h0},
    {1'b1, 6'h30, 32'h1234_5678, 32'h0},
    {1'b0, 6'h30, 32'h0,         32'h0},
    {1'b0, 6'h20, 32'h0,         32'hA5A5_A5A5},
    {1'b1, 6'h21, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 6'h21, 32'h0,         32'h0},
    {1'b0, 6'h20, 32'h0,         32'hA5A5_A5A5},
    {1'b0, 6'h14, 32'h0,         32'h0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req_tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); src[v] = 1'b1;
    @(negedge clk); src[v] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R1");
    check(rdata, 32'h0, "R1");
    for (int k = 0; k < 4; k++) begin
      bus_read(6'(4 * k), rd);  check(rd, 32'h0, "R1");
      bus_read(6'(32 + 4 * k), rd); check(rd, 32'h0, "R1");
    end

    // register table: enable readback (R5), unmapped and misaligned (R8)
    for (int i = 0; i < 14; i++) begin
      if (TBL[i][70]) bus_write(TBL[i][69:64], TBL[i][63:32]);
      else begin
        bus_read(TBL[i][69:64], rd);
        check(rd, TBL[i][31:0], TBL[i][69:64] >= 6'h20 && TBL[i][69:64] < 6'h30
                                && TBL[i][65:64] == 2'b00 ? "R5" : "R8");
      end
    end
    for (int k = 0; k < 4; k++) bus_write(6'(32 + 4 * k), 32'h0);
    bus_read(6'h00, rd); check(rd, 32'h0, "R8");

    // capture while masked
    pulse(37); pulse(127); pulse(0);
    bus_read(6'h04, rd); check(rd, 32'h0000_0020, "R2");
    bus_read(6'h0C, rd); check(rd, 32'h8000_0000, "R2");
    bus_read(6'h00, rd); check(rd, 32'h0000_0001, "R9");
    check({31'b0, irq}, 32'h0, "R6");

    // unmask another bit only, then the pending one
    bus_write(6'h24, 32'h0000_0100);
    check({31'b0, irq}, 32'h0, "R6");
    bus_write(6'h24, 32'h0000_0020);
    check({31'b0, irq}, 32'h1, "R6");

    // selective acknowledge
    pulse(40);
    bus_write(6'h04, 32'h0000_0020);
    bus_read(6'h04, rd); check(rd, 32'h0000_0100, "R4");
    check({31'b0, irq}, 32'h0, "R6");

    // rdata holds across idle and write cycles
    bus_read(6'h04, rd);
    repeat (3) @(negedge clk);
    check(rdata, 32'h0000_0100, "R10");
    bus_write(6'h24, 32'h0);
    check(rdata, 32'h0000_0100, "R10");

    // level held high: no recapture after acknowledge
    @(negedge clk); src[64] = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(6'h08, 32'h0000_0001);
    repeat (2) @(negedge clk);
    bus_read(6'h08, rd); check(rd, 32'h0, "R3");
    @(negedge clk); src[64] = 1'b0;
    @(negedge clk); src[64] = 1'b1;
    @(negedge clk);
    bus_read(6'h08, rd); check(rd, 32'h0000_0001, "R3");
    src[64] = 1'b0;

    // same-cycle edge and acknowledge on vector 96
    bus_write(6'h0C, 32'hFFFF_FFFF);
    @(negedge clk);
    src[96] = 1'b1; req = 1'b1; we = 1'b1; addr = 6'h0C; wdata = 32'h0000_0001;
    @(negedge clk);
    req = 1'b0; we = 1'b0; src[96] = 1'b0;
    bus_read(6'h0C, rd); check(rd, 32'h0000_0001, "R7");

    // unmapped write leaves pending untouched
    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_read(6'h0C, rd); check(rd, 32'h0000_0001, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule